// File: doc/BRIEF.md
# Mask-Set Event Status Register

This block holds a 32-bit message-interrupt mask for each of four virtual functions. Local firmware and the host each have a simple write port and a read port for the masks. Every mask write is compared with the value it replaces. If any mask bit goes from 0 to 1 and the global event enable is on, a sticky status bit for that function is set.

Firmware reads the status bits through one 32-bit status word and clears them by writing 1s. While any status bit is 1 and the interrupt mask input is low, a level interrupt is driven. The interrupt stays up until firmware clears every status bit that is set. Bus decoding is outside this block: plain write enables, function selects and data words take its place.

Top module: `vf_mask_evt`

## Requirements
- R1: A mask write for function i in which any mask bit goes from 0 to 1 sets status bit i. The bit is visible on `stat_rd_data` after the clock edge that takes the write.
- R2: Writes from firmware and from the host both set status. If both agents write the same function in the same cycle, the host data is stored, and rising bits are found by comparing the old mask with the host data.
- R3: While `evt_enable` is 0 in the write cycle, a 0-to-1 mask change leaves the status unchanged. The mask itself is still updated.
- R4: A status clear strobe with bit i of `stat_clr_data` at 1 clears status bit i. Data bits at 0 leave their status bits unchanged.
- R5: `irq` is 1 exactly when some status bit is 1 and `intr_mask` is 0. It stays 1 until all set status bits are cleared.
- R6: Status bit i (for i = 0 to 3) belongs to function i. Bits 31:4 of `stat_rd_data` always read 0.
- R7: After reset, all status bits are 0, all masks are 0 and `irq` is 0.
- R8: A mask write that only clears bits, or that only rewrites bits already at 1, does not set status.
- R9: If a set event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R10: Both agents can read any function's mask. After a write, the read port returns the newly written value from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_enable | input | 1 | Global enable for setting status on a mask rise |
| intr_mask | input | 1 | 1 blocks the interrupt output |
| fw_wr_en | input | 1 | Firmware mask write strobe |
| fw_wr_fn | input | 2 | Function selected by the firmware write |
| fw_wr_data | input | 32 | Firmware mask write data |
| host_wr_en | input | 1 | Host mask write strobe |
| host_wr_fn | input | 2 | Function selected by the host write |
| host_wr_data | input | 32 | Host mask write data |
| fw_rd_fn | input | 2 | Function selected for the firmware mask read |
| fw_rd_mask | output | 32 | Mask of the function selected by firmware |
| host_rd_fn | input | 2 | Function selected for the host mask read |
| host_rd_mask | output | 32 | Mask of the function selected by the host |
| stat_clr_en | input | 1 | Status write-1-to-clear strobe |
| stat_clr_data | input | 32 | Status bits to clear (1 = clear) |
| stat_rd_data | output | 32 | Status word; reserved bits read 0 |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: four functions, 32-bit masks and a 32-bit status word. These values make the reserved upper status bits, the mask bits at both ends of the word, and every function index reachable. Directed scenarios cover the same-cycle collisions: two agents writing one function, and a set event meeting a clear. They also cover writes that only clear or rewrite mask bits, and the enable and interrupt-mask inputs.

// File: rtl/vf_mask_evt_pkg.sv
package vf_mask_evt_pkg;

  // Which agent supplies the data committed to a mask register
  typedef enum logic {
    SRC_FW   = 1'b0,
    SRC_HOST = 1'b1
  } wr_src_e;

  // Rising-bit detector: 1 when any bit goes from 0 to 1
  function automatic logic any_rise(input logic [31:0] old_v, input logic [31:0] new_v);
    return |(new_v & ~old_v);
  endfunction

endpackage

// File: rtl/vf_mask_evt_wr_sel.sv
module vf_mask_evt_wr_sel
  import vf_mask_evt_pkg::*;
#(
  parameter int NUM_FN = 4,
  parameter int MASK_W = 32,
  parameter int FN_W   = 2
) (
  input  logic                           fw_wr_en,
  input  logic [FN_W-1:0]                fw_wr_fn,
  input  logic [MASK_W-1:0]              fw_wr_data,
  input  logic                           host_wr_en,
  input  logic [FN_W-1:0]                host_wr_fn,
  input  logic [MASK_W-1:0]              host_wr_data,
  output logic [NUM_FN-1:0]              fn_we,
  output logic [NUM_FN-1:0][MASK_W-1:0]  fn_wdata
);

  for (genvar gi = 0; gi < NUM_FN; gi++) begin : g_fn
    logic    fw_hit;
    logic    host_hit;
    wr_src_e src;

    always_comb begin
      fw_hit   = fw_wr_en   && (fw_wr_fn   == FN_W'(gi));
      host_hit = host_wr_en && (host_wr_fn == FN_W'(gi));
      src      = host_hit ? SRC_HOST : SRC_FW;
      fn_we[gi] = fw_hit || host_hit;
      fn_wdata[gi] = (src == SRC_HOST) ? host_wr_data : fw_wr_data;
    end
  end

endmodule

// File: rtl/vf_mask_evt_bank.sv
module vf_mask_evt_bank
  import vf_mask_evt_pkg::*;
#(
  parameter int NUM_FN = 4,
  parameter int MASK_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_FN-1:0]              fn_we,
  input  logic [NUM_FN-1:0][MASK_W-1:0]  fn_wdata,
  output logic [NUM_FN-1:0][MASK_W-1:0]  mask_q,
  output logic [NUM_FN-1:0]              fn_rise
);

  for (genvar gi = 0; gi < NUM_FN; gi++) begin : g_reg
    logic [MASK_W-1:0] mask_d;

    always_comb begin
      mask_d      = fn_we[gi] ? fn_wdata[gi] : mask_q[gi];
      fn_rise[gi] = fn_we[gi] && (|(fn_wdata[gi] & ~mask_q[gi]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[gi] <= '0;
      end else if (fn_we[gi]) begin
        mask_q[gi] <= mask_d;
      end
    end
  end

endmodule

// File: rtl/vf_mask_evt_status.sv
module vf_mask_evt_status #(
  parameter int NUM_FN = 4,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_enable,
  input  logic              intr_mask,
  input  logic [NUM_FN-1:0] fn_rise,
  input  logic              stat_clr_en,
  input  logic [REG_W-1:0]  stat_clr_data,
  output logic [REG_W-1:0]  stat_rd_data,
  output logic              irq
);

  localparam int RSV_W = REG_W - NUM_FN;

  logic [NUM_FN-1:0] stat_q;
  logic [NUM_FN-1:0] stat_d;
  logic [NUM_FN-1:0] set_vec;
  logic [NUM_FN-1:0] clr_vec;
  logic              stat_ce;

  always_comb begin
    set_vec = evt_enable ? fn_rise : '0;
    clr_vec = stat_clr_en ? stat_clr_data[NUM_FN-1:0] : '0;
    // a set in the same cycle as a clear wins
    stat_d  = (stat_q & ~clr_vec) | set_vec;
    stat_ce = (|set_vec) || (|clr_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_ce) begin
      stat_q <= stat_d;
    end
  end

  always_comb begin
    stat_rd_data = {{RSV_W{1'b0}}, stat_q};
    irq          = (|stat_q) && !intr_mask;
  end

endmodule

// File: rtl/vf_mask_evt.sv
module vf_mask_evt
  import vf_mask_evt_pkg::*;
#(
  parameter int NUM_FN = 4,
  parameter int MASK_W = 32,
  parameter int REG_W  = 32,
  parameter int FN_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_enable,
  input  logic              intr_mask,
  input  logic              fw_wr_en,
  input  logic [FN_W-1:0]   fw_wr_fn,
  input  logic [MASK_W-1:0] fw_wr_data,
  input  logic              host_wr_en,
  input  logic [FN_W-1:0]   host_wr_fn,
  input  logic [MASK_W-1:0] host_wr_data,
  input  logic [FN_W-1:0]   fw_rd_fn,
  output logic [MASK_W-1:0] fw_rd_mask,
  input  logic [FN_W-1:0]   host_rd_fn,
  output logic [MASK_W-1:0] host_rd_mask,
  input  logic              stat_clr_en,
  input  logic [REG_W-1:0]  stat_clr_data,
  output logic [REG_W-1:0]  stat_rd_data,
  output logic              irq
);

  logic [NUM_FN-1:0]             fn_we;
  logic [NUM_FN-1:0][MASK_W-1:0] fn_wdata;
  logic [NUM_FN-1:0][MASK_W-1:0] mask_q;
  logic [NUM_FN-1:0]             fn_rise;

  vf_mask_evt_wr_sel #(
    .NUM_FN (NUM_FN),
    .MASK_W (MASK_W),
    .FN_W   (FN_W)
  ) u_wr_sel (
    .fw_wr_en     (fw_wr_en),
    .fw_wr_fn     (fw_wr_fn),
    .fw_wr_data   (fw_wr_data),
    .host_wr_en   (host_wr_en),
    .host_wr_fn   (host_wr_fn),
    .host_wr_data (host_wr_data),
    .fn_we        (fn_we),
    .fn_wdata     (fn_wdata)
  );

  vf_mask_evt_bank #(
    .NUM_FN (NUM_FN),
    .MASK_W (MASK_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .fn_we    (fn_we),
    .fn_wdata (fn_wdata),
    .mask_q   (mask_q),
    .fn_rise  (fn_rise)
  );

  vf_mask_evt_status #(
    .NUM_FN (NUM_FN),
    .REG_W  (REG_W)
  ) u_status (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_enable    (evt_enable),
    .intr_mask     (intr_mask),
    .fn_rise       (fn_rise),
    .stat_clr_en   (stat_clr_en),
    .stat_clr_data (stat_clr_data),
    .stat_rd_data  (stat_rd_data),
    .irq           (irq)
  );

  always_comb begin
    fw_rd_mask   = mask_q[fw_rd_fn];
    host_rd_mask = mask_q[host_rd_fn];
  end

endmodule

// File: rtl/vf_mask_evt_chk.sv
module vf_mask_evt_chk #(
  parameter int NUM_FN = 4,
  parameter int REG_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_enable,
  input logic              intr_mask,
  input logic [NUM_FN-1:0] fn_rise,
  input logic              stat_clr_en,
  input logic [REG_W-1:0]  stat_clr_data,
  input logic [REG_W-1:0]  stat_rd_data,
  input logic              irq
);

  // R1 / R9: an enabled rise always leaves its bit set, even against a clear
  a_r1_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_enable && (|fn_rise)) |=>
      ((stat_rd_data[NUM_FN-1:0] & $past(fn_rise)) == $past(fn_rise)));

  // R3: with the enable off no status bit goes from 0 to 1
  a_r3_no_set_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_enable |=> ((stat_rd_data & ~$past(stat_rd_data)) == '0));

  // R4: a clear with no possible set leaves the chosen bits at 0
  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr_en && !evt_enable) |=> ((stat_rd_data & $past(stat_clr_data)) == '0));

  // R4: without a clear strobe no status bit falls
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr_en |=> ((~stat_rd_data & $past(stat_rd_data)) == '0));

  // R5: interrupt level follows status and mask
  a_r5_irq_up: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_rd_data != '0) && !intr_mask) |-> irq);

  a_r5_irq_down: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_mask || (stat_rd_data == '0)) |-> !irq);

  // R6: reserved status bits stay 0
  a_r6_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_data[REG_W-1:NUM_FN] == '0);

endmodule

bind vf_mask_evt vf_mask_evt_chk #(
  .NUM_FN (NUM_FN),
  .REG_W  (REG_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .evt_enable    (evt_enable),
  .intr_mask     (intr_mask),
  .fn_rise       (fn_rise),
  .stat_clr_en   (stat_clr_en),
  .stat_clr_data (stat_clr_data),
  .stat_rd_data  (stat_rd_data),
  .irq           (irq)
);

// File: tb/vf_mask_evt_bench.sv
module vf_mask_evt_bench;

  logic        clk;
  logic        rst_n;
  logic        evt_enable;
  logic        intr_mask;
  logic        fw_wr_en;
  logic [1:0]  fw_wr_fn;
  logic [31:0] fw_wr_data;
  logic        host_wr_en;
  logic [1:0]  host_wr_fn;
  logic [31:0] host_wr_data;
  logic [1:0]  fw_rd_fn;
  logic [31:0] fw_rd_mask;
  logic [1:0]  host_rd_fn;
  logic [31:0] host_rd_mask;
  logic        stat_clr_en;
  logic [31:0] stat_clr_data;
  logic [31:0] stat_rd_data;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  vf_mask_evt u_vf_mask_evt (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_enable    (evt_enable),
    .intr_mask     (intr_mask),
    .fw_wr_en      (fw_wr_en),
    .fw_wr_fn      (fw_wr_fn),
    .fw_wr_data    (fw_wr_data),
    .host_wr_en    (host_wr_en),
    .host_wr_fn    (host_wr_fn),
    .host_wr_data  (host_wr_data),
    .fw_rd_fn      (fw_rd_fn),
    .fw_rd_mask    (fw_rd_mask),
    .host_rd_fn    (host_rd_fn),
    .host_rd_mask  (host_rd_mask),
    .stat_clr_en   (stat_clr_en),
    .stat_clr_data (stat_clr_data),
    .stat_rd_data  (stat_rd_data),
    .irq           (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus, driven at a falling edge, results seen at the next one
  task automatic cyc(input logic fwe, input logic [1:0] ff, input logic [31:0] fd,
                     input logic hwe, input logic [1:0] hf, input logic [31:0] hd,
                     input logic ce, input logic [31:0] cd);
    fw_wr_en = fwe; fw_wr_fn = ff; fw_wr_data = fd;
    host_wr_en = hwe; host_wr_fn = hf; host_wr_data = hd;
    stat_clr_en = ce; stat_clr_data = cd;
    @(negedge clk);
    fw_wr_en = 1'b0; host_wr_en = 1'b0; stat_clr_en = 1'b0;
    fw_wr_data = '0; host_wr_data = '0; stat_clr_data = '0;
  endtask

  task automatic fw_wr(input logic [1:0] f, input logic [31:0] d);
    cyc(1'b1, f, d, 1'b0, 2'd0, '0, 1'b0, '0);
  endtask

  task automatic clr(input logic [31:0] d);
    cyc(1'b0, 2'd0, '0, 1'b0, 2'd0, '0, 1'b1, d);
  endtask

  task automatic t_reset();
    chk("R7 status after reset", stat_rd_data, 32'h0);
    chk("R7 irq after reset", {31'b0, irq}, 32'h0);
    for (int f = 0; f < 4; f++) begin
      fw_rd_fn = 2'(f);
      #1;
      chk("R7 mask after reset", fw_rd_mask, 32'h0);
    end
  endtask

  task automatic t_fw_rise();
    fw_wr(2'd1, 32'h0000_0001);
    chk("R1 fw rise sets bit1", stat_rd_data, 32'h0000_0002);
    chk("R5 irq raised", {31'b0, irq}, 32'h1);
    fw_rd_fn = 2'd1; host_rd_fn = 2'd1; #1;
    chk("R10 fw reads mask1", fw_rd_mask, 32'h0000_0001);
    chk("R10 host reads mask1", host_rd_mask, 32'h0000_0001);
  endtask

  task automatic t_host_rise();
    cyc(1'b0, 2'd0, '0, 1'b1, 2'd2, 32'h8000_0000, 1'b0, '0);
    chk("R2 host rise sets bit2", stat_rd_data, 32'h0000_0006);
    host_rd_fn = 2'd2; #1;
    chk("R10 host reads mask2", host_rd_mask, 32'h8000_0000);
  endtask

  task automatic t_clear();
    clr(32'h0);
    chk("R4 zero clear no effect", stat_rd_data, 32'h0000_0006);
    clr(32'h0000_0002);
    chk("R4 clear bit1", stat_rd_data, 32'h0000_0004);
    chk("R5 irq held by bit2", {31'b0, irq}, 32'h1);
    clr(32'hFFFF_FFFF);
    chk("R4 clear all", stat_rd_data, 32'h0);
    chk("R5 irq drops after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_no_rise();
    fw_wr(2'd1, 32'h0);
    chk("R8 clear-only write no set", stat_rd_data, 32'h0);
    fw_wr(2'd1, 32'h0000_0001);
    chk("R1 re-rise sets bit1", stat_rd_data, 32'h0000_0002);
    clr(32'h0000_0002);
    fw_wr(2'd1, 32'h0000_0001);
    chk("R8 rewrite of ones no set", stat_rd_data, 32'h0);
    fw_wr(2'd1, 32'h0000_0003);
    chk("R1 one new bit sets", stat_rd_data, 32'h0000_0002);
    clr(32'h0000_0002);
  endtask

  task automatic t_disabled();
    evt_enable = 1'b0;
    fw_wr(2'd3, 32'h0000_000F);
    chk("R3 disabled rise no set", stat_rd_data, 32'h0);
    chk("R3 disabled no irq", {31'b0, irq}, 32'h0);
    fw_rd_fn = 2'd3; #1;
    chk("R3 mask still written", fw_rd_mask, 32'h0000_000F);
    evt_enable = 1'b1;
    fw_wr(2'd3, 32'h0000_000F);
    chk("R8 same value after enable", stat_rd_data, 32'h0);
    fw_wr(2'd3, 32'h8000_000F);
    chk("R6 bit3 for function 3", stat_rd_data, 32'h0000_0008);
    clr(32'h0000_0008);
  endtask

  task automatic t_both_agents();
    cyc(1'b1, 2'd0, 32'h0000_00FF, 1'b1, 2'd0, 32'h0000_0F00, 1'b0, '0);
    fw_rd_fn = 2'd0; #1;
    chk("R2 host wins same fn", fw_rd_mask, 32'h0000_0F00);
    chk("R6 bit0 for function 0", stat_rd_data, 32'h0000_0001);
    clr(32'h0000_0001);
    // host rewrites same bits while fw would raise new ones: host data rules
    cyc(1'b1, 2'd0, 32'h0000_0FFF, 1'b1, 2'd0, 32'h0000_0F00, 1'b0, '0);
    chk("R2 rise judged on host data", stat_rd_data, 32'h0);
    // different functions in one cycle, both rise
    cyc(1'b1, 2'd1, 32'h0000_0007, 1'b1, 2'd2, 32'hC000_0000, 1'b0, '0);
    chk("R2 two fns same cycle", stat_rd_data, 32'h0000_0006);
    clr(32'h0000_0006);
  endtask

  task automatic t_race();
    cyc(1'b1, 2'd0, 32'h0000_1F00, 1'b0, 2'd0, '0, 1'b1, 32'h0000_0001);
    chk("R9 set beats clear", stat_rd_data, 32'h0000_0001);
    cyc(1'b1, 2'd0, 32'h0000_3F00, 1'b0, 2'd0, '0, 1'b1, 32'h0000_0002);
    chk("R9 other bit clear keeps set", stat_rd_data, 32'h0000_0001);
  endtask

  task automatic t_irq_mask();
    intr_mask = 1'b1; #1;
    chk("R5 masked irq low", {31'b0, irq}, 32'h0);
    chk("R5 status kept while masked", stat_rd_data, 32'h0000_0001);
    intr_mask = 1'b0; #1;
    chk("R5 unmasked irq high", {31'b0, irq}, 32'h1);
    clr(32'h0000_0001);
    chk("R5 irq low after clear", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    evt_enable = 1'b1; intr_mask = 1'b0;
    fw_wr_en = 1'b0; fw_wr_fn = '0; fw_wr_data = '0;
    host_wr_en = 1'b0; host_wr_fn = '0; host_wr_data = '0;
    fw_rd_fn = '0; host_rd_fn = '0;
    stat_clr_en = 1'b0; stat_clr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fw_rise();
    t_host_rise();
    t_clear();
    t_no_rise();
    t_disabled();
    t_both_agents();
    t_race();
    t_irq_mask();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule